// File: doc/BRIEF.md
# T1 Extended-Superframe Framing-Bit Generator

This block sits in a T1 transmit path and receives the outgoing line stream one bit per clock. The stream is made of frames of `FRAME_BITS` bits (193 on a real line), each starting with one framing bit and followed by channel bytes of `CH_BITS` bits. Twenty-four frames form an extended superframe. The block rewrites the framing bit of every frame. Frames 4, 8, 12, 16, 20 and 24 carry the alignment pattern. Frames 2, 6, 10, 14, 18 and 22 carry a CRC-6 check word. The odd frames carry a data-link bit taken from a side input. Robbed-bit signaling from a signaling input can also overwrite the last bit of each channel in frames 6, 12, 18 and 24.

A start-of-superframe marker aligns the internal position counters. Control inputs can disable the whole generator, in which case the stream passes through untouched. They can also hand any single framing-bit class back to the input stream, or freeze the signaling value for a whole superframe. A buffer-reset control clears the output register, the CRC state and the alignment. The position tracker is a three-state machine. `ST_HUNT` means no alignment; the block leaves it for `ST_FBIT` when the marker arrives. `ST_FBIT` means the current bit is a framing bit and always moves to `ST_PAYLOAD`. `ST_PAYLOAD` moves back to `ST_FBIT` on the last bit of a frame, or whenever a marker arrives. The buffer reset sends any state to `ST_HUNT`.

Top module: `t1_esf_fbit_gen`

## Requirements
- R1: `sd_out` repeats `sd_in` one clock later for every bit that is not a framing bit and not a signaling slot.
- R2: While `ctl_gen_off` is 1, every bit, including framing bits and signaling slots, leaves unchanged one clock later.
- R3: In frames 4, 8, 12, 16, 20 and 24, the framing bit is 0,0,1,0,1,1 in that frame order. When `ctl_sync_pass` is 1, it is instead the input bit.
- R4: In frames 2, 6, 10, 14, 18 and 22, the framing bit is CRC-6 bit 5 down to bit 0 in that order. The CRC uses x^6+x+1, is the remainder of the message times x^6, and covers the previous superframe's output with every framing bit counted as 1. The first superframe after alignment or buffer reset sends zeros.
- R5: When `ctl_crc_pass` is 1, the CRC framing positions carry the input bit.
- R6: In odd frames, the framing bit is `dl_in`. When `ctl_dl_pass` is 1, it is the input bit.
- R7: The three pass controls have no effect while `ctl_gen_off` is 1.
- R8: In frames 6, 12, 18 and 24, the last bit of each channel byte (payload bit index k*`CH_BITS`, counting the framing bit as 0) is replaced by `sig_in`.
- R9: When `ctl_sig_lock` is 1, signaling slots carry the value that `sig_in` had during the framing bit of frame 1 of the current superframe.
- R10: `sof_in` marks the current bit as the framing bit of frame 1 and realigns at once. Without a marker, the frame count wraps from 24 to 1. Before the first marker, the stream passes unchanged.
- R11: While `ctl_buf_reset` is 1, `sd_out` is 0 one clock later and the CRC state and alignment are cleared. After release, the stream passes unchanged until the next marker.
- R12: After reset `sd_out` is 0 and the block is unaligned. Control inputs at 0 select full generation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sd_in | input | 1 | Serial transmit data in |
| sof_in | input | 1 | High on the framing bit of frame 1 |
| dl_in | input | 1 | Data-link bit for odd frames |
| sig_in | input | 1 | Robbed-bit signaling value |
| ctl_gen_off | input | 1 | Disable all insertion |
| ctl_sync_pass | input | 1 | Take alignment-pattern bits from input |
| ctl_crc_pass | input | 1 | Take CRC bits from input |
| ctl_dl_pass | input | 1 | Take data-link bits from input |
| ctl_sig_lock | input | 1 | Freeze signaling per superframe |
| ctl_buf_reset | input | 1 | Clear output, CRC and alignment |
| sd_out | output | 1 | Serial transmit data out, one clock latency |

## Verification
The bench builds the block with `FRAME_BITS` = 25 and `CH_BITS` = 8, which gives three channel bytes per frame and 600-bit superframes. At that size, chains of superframes fit in a short run. Each CRC word can then be checked against the previous superframe's output. The run also covers wrap without a marker, realignment in mid-superframe, each pass control and the lock mode. All of these use the same framing positions and signaling slots as a full-width line.

// File: rtl/t1fg_pkg.sv
package t1fg_pkg;

    typedef enum logic [1:0] {
        ST_HUNT    = 2'd0,
        ST_FBIT    = 2'd1,
        ST_PAYLOAD = 2'd2
    } pos_state_e;

    localparam int SF_FRAMES = 24;
    localparam int CRC_W     = 6;
    // alignment pattern, MSB belongs to frame 4
    localparam logic [5:0] SYNC_WORD = 6'b001011;

    function automatic logic [CRC_W-1:0] crc6_step(input logic [CRC_W-1:0] r, input logic b);
        logic fb;
        fb = r[CRC_W-1] ^ b;
        return {r[CRC_W-2:0], 1'b0} ^ (fb ? 6'b000011 : 6'b000000);
    endfunction

endpackage

// File: rtl/t1fg_position.sv
module t1fg_position
    import t1fg_pkg::*;
#(
    parameter int FRAME_BITS = 193,
    parameter int CH_BITS    = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       buf_reset,
    input  logic       sof_in,
    output logic       aligned,
    output logic       is_fbit,
    output logic       sf_start,
    output logic       sig_slot,
    output logic [4:0] frame_no
);
    localparam int PW = $clog2(FRAME_BITS);
    localparam int CW = (CH_BITS > 1) ? $clog2(CH_BITS) : 1;
    localparam logic [PW-1:0] LAST_POS = PW'(FRAME_BITS - 1);
    localparam logic [CW-1:0] LAST_CHB = CW'(CH_BITS - 1);

    pos_state_e    state_q, state_d;
    logic [PW-1:0] pos_q, cur_pos;
    logic [4:0]    frm_q, cur_frm;
    logic [CW-1:0] chb_q, cur_chb;
    logic          algn;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_HUNT;
            pos_q   <= '0;
            frm_q   <= 5'd1;
            chb_q   <= '0;
        end else if (buf_reset) begin
            state_q <= ST_HUNT;
            pos_q   <= '0;
            frm_q   <= 5'd1;
            chb_q   <= '0;
        end else begin
            state_q <= state_d;
            if (algn) begin
                pos_q <= cur_pos;
                frm_q <= cur_frm;
                chb_q <= cur_chb;
            end
        end
    end

    always_comb begin
        cur_pos = pos_q;
        cur_frm = frm_q;
        cur_chb = chb_q;
        algn    = 1'b0;
        if (sof_in) begin
            cur_pos = '0;
            cur_frm = 5'd1;
            cur_chb = '0;
            algn    = 1'b1;
        end else begin
            unique case (state_q)
                ST_HUNT: algn = 1'b0;
                ST_FBIT: begin
                    algn    = 1'b1;
                    cur_pos = PW'(1);
                    cur_chb = '0;
                end
                ST_PAYLOAD: begin
                    algn = 1'b1;
                    if (pos_q == LAST_POS) begin
                        cur_pos = '0;
                        cur_frm = (frm_q == 5'(SF_FRAMES)) ? 5'd1 : frm_q + 5'd1;
                    end else begin
                        cur_pos = pos_q + PW'(1);
                        cur_chb = (chb_q == LAST_CHB) ? '0 : chb_q + CW'(1);
                    end
                end
                default: algn = 1'b0;
            endcase
        end
        if (buf_reset) algn = 1'b0;

        if (!algn)                state_d = ST_HUNT;
        else if (cur_pos == '0)   state_d = ST_FBIT;
        else                      state_d = ST_PAYLOAD;

        aligned  = algn;
        frame_no = cur_frm;
        is_fbit  = algn && (cur_pos == '0);
        sf_start = is_fbit && (cur_frm == 5'd1);
        sig_slot = algn && (cur_pos != '0) && (cur_chb == LAST_CHB) &&
                   ((cur_frm == 5'd6) || (cur_frm == 5'd12) ||
                    (cur_frm == 5'd18) || (cur_frm == 5'd24));
    end

    AST_FRAME_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        aligned |-> (frame_no >= 5'd1 && frame_no <= 5'(SF_FRAMES))); // R10
    AST_RESET_TO_HUNT: assert property (@(posedge clk) disable iff (!rst_n)
        buf_reset |=> (state_q == ST_HUNT)); // R11

endmodule

// File: rtl/t1fg_crc6.sv
module t1fg_crc6
    import t1fg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             buf_reset,
    input  logic             aligned,
    input  logic             is_fbit,
    input  logic             sf_start,
    input  logic             bit_val,
    output logic [CRC_W-1:0] crc_word
);
    logic [CRC_W-1:0] acc_q, send_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q  <= '0;
            send_q <= '0;
        end else if (buf_reset) begin
            acc_q  <= '0;
            send_q <= '0;
        end else if (aligned) begin
            if (sf_start) begin
                send_q <= acc_q;
                acc_q  <= crc6_step('0, 1'b1);
            end else begin
                acc_q  <= crc6_step(acc_q, is_fbit ? 1'b1 : bit_val);
            end
        end
    end

    assign crc_word = send_q;

    AST_CRC_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        buf_reset |=> (crc_word == '0)); // R11
    AST_CRC_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!sf_start && !buf_reset) |=> $stable(crc_word)); // R4

endmodule

// File: rtl/t1fg_insert.sv
module t1fg_insert
    import t1fg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             buf_reset,
    input  logic             sd_in,
    input  logic             dl_in,
    input  logic             sig_in,
    input  logic             gen_off,
    input  logic             sync_pass,
    input  logic             crc_pass,
    input  logic             dl_pass,
    input  logic             sig_lock,
    input  logic             aligned,
    input  logic             is_fbit,
    input  logic             sf_start,
    input  logic             sig_slot,
    input  logic [4:0]       frame_no,
    input  logic [CRC_W-1:0] crc_word,
    output logic             bit_sel
);
    logic sig_hold_q;
    logic sync_bit, crc_bit, sig_bit;
    int   sidx, cidx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         sig_hold_q <= 1'b0;
        else if (buf_reset) sig_hold_q <= 1'b0;
        else if (sf_start)  sig_hold_q <= sig_in;
    end

    always_comb begin
        sidx     = 6 - int'(frame_no[4:2]);
        cidx     = 5 - int'(frame_no[4:2]);
        sync_bit = (sidx >= 0 && sidx <= 5) ? SYNC_WORD[sidx[2:0]] : 1'b0;
        crc_bit  = (cidx >= 0 && cidx <= 5) ? crc_word[cidx[2:0]] : 1'b0;
        sig_bit  = sig_lock ? sig_hold_q : sig_in;
        bit_sel  = sd_in;
        if (aligned && !gen_off) begin
            if (is_fbit) begin
                unique case (frame_no[1:0])
                    2'b00:   bit_sel = sync_pass ? sd_in : sync_bit;
                    2'b10:   bit_sel = crc_pass  ? sd_in : crc_bit;
                    default: bit_sel = dl_pass   ? sd_in : dl_in;
                endcase
            end else if (sig_slot) begin
                bit_sel = sig_bit;
            end
        end
    end

    AST_SIG_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!sf_start && !buf_reset) |=> $stable(sig_hold_q)); // R9

endmodule

// File: rtl/t1_esf_fbit_gen.sv
module t1_esf_fbit_gen
    import t1fg_pkg::*;
#(
    parameter int FRAME_BITS = 193,
    parameter int CH_BITS    = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sd_in,
    input  logic sof_in,
    input  logic dl_in,
    input  logic sig_in,
    input  logic ctl_gen_off,
    input  logic ctl_sync_pass,
    input  logic ctl_crc_pass,
    input  logic ctl_dl_pass,
    input  logic ctl_sig_lock,
    input  logic ctl_buf_reset,
    output logic sd_out
);
    logic             aligned, is_fbit, sf_start, sig_slot, bit_sel;
    logic [4:0]       frame_no;
    logic [CRC_W-1:0] crc_word;

    t1fg_position #(.FRAME_BITS(FRAME_BITS), .CH_BITS(CH_BITS)) u_pos (
        .clk(clk), .rst_n(rst_n), .buf_reset(ctl_buf_reset), .sof_in(sof_in),
        .aligned(aligned), .is_fbit(is_fbit), .sf_start(sf_start),
        .sig_slot(sig_slot), .frame_no(frame_no)
    );

    t1fg_crc6 u_crc (
        .clk(clk), .rst_n(rst_n), .buf_reset(ctl_buf_reset), .aligned(aligned),
        .is_fbit(is_fbit), .sf_start(sf_start), .bit_val(bit_sel), .crc_word(crc_word)
    );

    t1fg_insert u_ins (
        .clk(clk), .rst_n(rst_n), .buf_reset(ctl_buf_reset), .sd_in(sd_in),
        .dl_in(dl_in), .sig_in(sig_in), .gen_off(ctl_gen_off),
        .sync_pass(ctl_sync_pass), .crc_pass(ctl_crc_pass), .dl_pass(ctl_dl_pass),
        .sig_lock(ctl_sig_lock), .aligned(aligned), .is_fbit(is_fbit),
        .sf_start(sf_start), .sig_slot(sig_slot), .frame_no(frame_no),
        .crc_word(crc_word), .bit_sel(bit_sel)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             sd_out <= 1'b0;
        else if (ctl_buf_reset) sd_out <= 1'b0;
        else                    sd_out <= bit_sel;
    end

    AST_GEN_OFF_TRANSPARENT: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_gen_off && !ctl_buf_reset) |=> (sd_out == $past(sd_in))); // R2
    AST_PAYLOAD_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (aligned && !is_fbit && !sig_slot && !ctl_buf_reset) |=> (sd_out == $past(sd_in))); // R1
    AST_BUF_RESET_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_buf_reset |=> !sd_out); // R11

endmodule

// File: tb/t1_esf_fbit_gen_tb.sv
`timescale 1ns/1ps
module t1_esf_fbit_gen_tb_top;
    localparam int FB = 25;
    localparam int CB = 8;
    localparam int SF = FB * 24;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst_n = 1'b0;
    logic sd_in = 0, sof_in = 0, dl_in = 0, sig_in = 0;
    logic c_off = 0, c_sync = 0, c_crc = 0, c_dl = 0, c_lock = 0, c_brst = 0;
    logic p_off = 0, p_sync = 0, p_crc = 0, p_dl = 0, p_lock = 0, p_brst = 0;
    logic sd_out;

    t1_esf_fbit_gen #(.FRAME_BITS(FB), .CH_BITS(CB)) dut_i (
        .clk(clk), .rst_n(rst_n), .sd_in(sd_in), .sof_in(sof_in), .dl_in(dl_in),
        .sig_in(sig_in), .ctl_gen_off(c_off), .ctl_sync_pass(c_sync),
        .ctl_crc_pass(c_crc), .ctl_dl_pass(c_dl), .ctl_sig_lock(c_lock),
        .ctl_buf_reset(c_brst), .sd_out(sd_out)
    );

    int total = 0, bad = 0;
    logic  exp_q[$];
    string tag_q[$];

    // reference model state
    logic       m_al = 0;
    int         m_pos = 0, m_frm = 1;
    logic       sf_bits[$];
    logic [5:0] m_send = 0;
    logic       m_hold = 0;
    logic       pat [6] = '{1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1};

    function automatic logic [5:0] div_crc();
        logic [6:0] r = '0;
        for (int i = 0; i < sf_bits.size() + 6; i++) begin
            r = {r[5:0], (i < sf_bits.size()) ? sf_bits[i] : 1'b0};
            if (r[6]) r = r ^ 7'b1000011;
        end
        return r[5:0];
    endfunction

    task automatic send_bit(input logic din, input logic sof, input logic dl, input logic sig);
        logic  e;
        string tg;
        @(negedge clk);
        sd_in = din; sof_in = sof; dl_in = dl; sig_in = sig;
        c_off = p_off; c_sync = p_sync; c_crc = p_crc; c_dl = p_dl;
        c_lock = p_lock; c_brst = p_brst;
        if (c_brst) begin
            e = 1'b0; tg = "R11";
            m_al = 0; sf_bits.delete(); m_send = '0; m_hold = 1'b0;
        end else begin
            if (sof) begin
                m_al = 1; m_pos = 0; m_frm = 1;
            end else if (m_al) begin
                m_pos++;
                if (m_pos == FB) begin
                    m_pos = 0;
                    m_frm = (m_frm == 24) ? 1 : m_frm + 1;
                end
            end
            if (m_al && m_pos == 0 && m_frm == 1) begin
                m_send = div_crc();
                sf_bits.delete();
                m_hold = sig;
            end
            e  = din;
            tg = m_al ? "R1" : "R10";
            if (m_al && !c_off) begin
                if (m_pos == 0) begin
                    if (m_frm % 4 == 0) begin
                        tg = "R3"; e = c_sync ? din : pat[(m_frm / 4) - 1];
                    end else if (m_frm % 4 == 2) begin
                        tg = c_crc ? "R5" : "R4";
                        e  = c_crc ? din : m_send[5 - (m_frm - 2) / 4];
                    end else begin
                        tg = "R6"; e = c_dl ? din : dl;
                    end
                end else if ((m_frm % 6 == 0) && ((m_pos - 1) % CB == CB - 1)) begin
                    tg = c_lock ? "R9" : "R8";
                    e  = c_lock ? m_hold : sig;
                end
            end else if (m_al && c_off) begin
                tg = (c_sync || c_crc || c_dl) ? "R7" : "R2";
            end
            if (m_al) sf_bits.push_back((m_pos == 0) ? 1'b1 : e);
        end
        exp_q.push_back(e);
        tag_q.push_back(tg);
    endtask

    task automatic run_bits(input int n, input int sof_at);
        for (int i = 0; i < n; i++)
            send_bit(1'($urandom), i == sof_at, 1'($urandom), 1'($urandom));
    endtask

    // monitor: scoreboard comparison
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                logic  e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                total++;
                if (sd_out !== e) begin
                    bad++;
                    $display("FAIL %s: sd_out actual=%b expected=%b at %0t", t, sd_out, e, $time);
                end
            end
        end
    end

    initial begin
        #(200000 * 5);
        total++; bad++;
        $display("FAIL watchdog (R1..): actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        total++;
        if (sd_out !== 1'b0) begin
            bad++;
            $display("FAIL R12: reset sd_out actual=%b expected=0", sd_out);
        end
        run_bits(40, -1);                 // R10 unaligned passthrough
        run_bits(3 * SF, 0);              // R10 wrap without marker, R3 R4 R6 R8
        p_sync = 1; run_bits(SF, 0);      // R3 pass
        p_sync = 0; p_crc = 1; run_bits(SF, 0);   // R5
        p_crc = 0; p_dl = 1; run_bits(SF, 0);     // R6 pass
        p_dl = 0;
        p_off = 1; p_sync = 1; p_crc = 1; p_dl = 1; run_bits(SF, 0); // R2 R7
        p_sync = 0; p_crc = 0; p_dl = 0; run_bits(SF, 0);           // R2
        p_off = 0; run_bits(SF, 0);                                 // R4 over transparent SF
        p_lock = 1; run_bits(2 * SF, 0);                            // R9
        p_lock = 0;
        run_bits(SF, 137);                                          // R10 realign
        run_bits(SF, -1);
        p_brst = 1; run_bits(3, -1);                                // R11
        p_brst = 0; run_bits(20, -1);
        run_bits(2 * SF, 0);
        repeat (4) @(posedge clk);
        #1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule